// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two IEEE-754 binary operands of either single (32-bit) or double (64-bit) width and sorts the pair into one of four relations: less, equal, greater or unordered. A NaN in either operand makes the pair unordered. The relation is written into two existing words that the caller passes in. Three condition bits go into a 16-bit floating-point status word, and the zero, parity and carry bits go into an integer flags word. Every other bit of both words passes through unchanged.

A mode input selects a signaling or a quiet compare. Both modes use the same flag encoding and differ only in when they raise the invalid-operation output. The block registers its result one cycle after a valid request. When no request is presented, the outputs hold their last values.

Top module: `fcmp_flags`

## Requirements
- R1: After reset, `valid_o`, `invalid_o`, `rel_o`, `status_o` and `flags_o` are all zero.
- R2: A request sampled with `valid_i`=1 produces its results and `valid_o`=1 on the next clock edge. On an edge where `valid_i`=0, `valid_o` drops to 0 and `rel_o`, `status_o`, `flags_o` and `invalid_o` keep their previous values.
- R3: `rel_o` encodes greater as 0, less as 1, equal as 2 and unordered as 3. In `status_o` the condition bits are bit 14, bit 10 and bit 8. Less sets only bit 8 (0x0100), equal sets only bit 14 (0x4000), greater sets none of them, and unordered sets all three (0x4500).
- R4: Every `status_o` bit outside 0x4500 equals the same bit of `status_i` from the request.
- R5: In `flags_o`, carry is bit 0, parity is bit 2 and zero is bit 6. Less sets carry only, equal sets zero only, greater sets none of the three, and unordered sets all three.
- R6: Every `flags_o` bit other than 0, 2 and 6 equals the same bit of `flags_i` from the request.
- R7: If either operand is a NaN (exponent all ones, fraction nonzero), in either format, the relation is unordered.
- R8: +0 and -0 compare equal. Other ordered operands are compared by sign and then by magnitude, and the magnitude order is reversed when both operands are negative. Infinities order as the largest magnitudes.
- R9: `fmt64_i`=0 compares `a_i[31:0]` and `b_i[31:0]` as single precision and ignores bits 63:32. `fmt64_i`=1 compares the full 64 bits as double precision.
- R10: With `quiet_i`=0 (signaling compare), `invalid_o` is 1 exactly when either operand is a NaN of any kind.
- R11: With `quiet_i`=1 (quiet compare), `invalid_o` is 1 exactly when either operand is a signaling NaN: a NaN whose fraction MSB is 0. A quiet NaN gives `invalid_o`=0 but the relation is still unordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Compare request |
| fmt64_i | input | 1 | 1 = double precision, 0 = single precision in the low 32 bits |
| quiet_i | input | 1 | 1 = quiet compare, 0 = signaling compare |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| status_i | input | 16 | Status word to be updated |
| flags_i | input | FLAG_W (32) | Integer flags word to be updated |
| valid_o | output | 1 | Result valid, one cycle after the request |
| rel_o | output | 2 | Relation code |
| status_o | output | 16 | Merged status word |
| flags_o | output | FLAG_W (32) | Merged flags word |
| invalid_o | output | 1 | Invalid-operation indication |

## Verification
The main compare is driven with positive pairs, negative pairs, mixed-sign pairs, signed zeros, infinities and equal values in both formats. These patterns separate a plain magnitude compare from true sign-magnitude ordering, and they expose a missing inversion for negative pairs. NaN operands are placed in each position, both quiet and signaling, in both modes. This tells the unordered classification apart from the invalid rule, which differs by mode. Busy status and flags words with every other bit set, and single-precision operands with garbage in the upper half, show that nothing outside the compare bits and the selected format leaks into the result.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned MAG_W = XLEN - 1;

  localparam int unsigned STS_W   = 16;
  localparam int unsigned STS_C3  = 14;
  localparam int unsigned STS_C2  = 10;
  localparam int unsigned STS_C0  = 8;
  localparam logic [STS_W-1:0] STS_MASK =
    STS_W'((1 << STS_C3) | (1 << STS_C2) | (1 << STS_C0));

  localparam int unsigned FL_CF = 0;
  localparam int unsigned FL_PF = 2;
  localparam int unsigned FL_ZF = 6;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             snan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } opnd_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] val_i,
  output opnd_t        info_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = val_i[W-2 -: EXP_W];
  assign frac_f = val_i[FRAC_W-1:0];

  always_comb begin
    info_o.sign = val_i[W-1];
    info_o.nan  = (&exp_f) && (|frac_f);
    // quiet bit is the fraction MSB
    info_o.snan = info_o.nan && !frac_f[FRAC_W-1];
    info_o.zero = ~|val_i[W-2:0];
    info_o.mag  = MAG_W'(val_i[W-2:0]);
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
(
  input  opnd_t a_i,
  input  opnd_t b_i,
  input  logic  quiet_i,
  output rel_e  rel_o,
  output logic  invalid_o
);
  logic mag_lt, mag_eq;

  assign mag_lt = a_i.mag < b_i.mag;
  assign mag_eq = a_i.mag == b_i.mag;

  always_comb begin
    if (a_i.nan || b_i.nan)          rel_o = REL_UN;
    else if (a_i.zero && b_i.zero)   rel_o = REL_EQ;
    else if (a_i.sign != b_i.sign)   rel_o = a_i.sign ? REL_LT : REL_GT;
    else if (mag_eq)                 rel_o = REL_EQ;
    else if (mag_lt ^ a_i.sign)      rel_o = REL_LT;
    else                             rel_o = REL_GT;
  end

  assign invalid_o = quiet_i ? (a_i.snan || b_i.snan) : (a_i.nan || b_i.nan);
endmodule

// File: rtl/fcmp_merge.sv
module fcmp_merge
  import fcmp_pkg::*;
#(
  parameter int unsigned FLAG_W = 32
) (
  input  rel_e              rel_i,
  input  logic [STS_W-1:0]  status_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [STS_W-1:0]  status_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [FLAG_W-1:0] FL_MASK =
    FLAG_W'((1 << FL_CF) | (1 << FL_PF) | (1 << FL_ZF));

  logic [STS_W-1:0]  cc;
  logic [FLAG_W-1:0] fl;

  always_comb begin
    cc = '0;
    fl = '0;
    unique case (rel_i)
      REL_LT: begin cc[STS_C0] = 1'b1; fl[FL_CF] = 1'b1; end
      REL_EQ: begin cc[STS_C3] = 1'b1; fl[FL_ZF] = 1'b1; end
      REL_UN: begin
        cc[STS_C3] = 1'b1; cc[STS_C2] = 1'b1; cc[STS_C0] = 1'b1;
        fl[FL_ZF]  = 1'b1; fl[FL_PF]  = 1'b1; fl[FL_CF]  = 1'b1;
      end
      default: ;
    endcase
  end

  assign status_o = (status_i & ~STS_MASK) | cc;
  assign flags_o  = (flags_i & ~FL_MASK) | fl;
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
  import fcmp_pkg::*;
#(
  parameter int unsigned FLAG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              fmt64_i,
  input  logic              quiet_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [STS_W-1:0]  status_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic [1:0]        rel_o,
  output logic [STS_W-1:0]  status_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              invalid_o
);
  localparam int unsigned NOPND = 2;

  logic [XLEN-1:0] opnd [NOPND];
  opnd_t           sp_info [NOPND];
  opnd_t           dp_info [NOPND];
  opnd_t           sel_info [NOPND];

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    fcmp_classify #(.EXP_W(8), .FRAC_W(23)) i_sp (
      .val_i (opnd[g][31:0]),
      .info_o(sp_info[g])
    );
    fcmp_classify #(.EXP_W(11), .FRAC_W(52)) i_dp (
      .val_i (opnd[g]),
      .info_o(dp_info[g])
    );
    assign sel_info[g] = fmt64_i ? dp_info[g] : sp_info[g];
  end

  rel_e              rel_d;
  logic              inv_d;
  logic [STS_W-1:0]  sts_d;
  logic [FLAG_W-1:0] fl_d;

  fcmp_order i_order (
    .a_i      (sel_info[0]),
    .b_i      (sel_info[1]),
    .quiet_i  (quiet_i),
    .rel_o    (rel_d),
    .invalid_o(inv_d)
  );

  fcmp_merge #(.FLAG_W(FLAG_W)) i_merge (
    .rel_i   (rel_d),
    .status_i(status_i),
    .flags_i (flags_i),
    .status_o(sts_d),
    .flags_o (fl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      rel_o     <= '0;
      status_o  <= '0;
      flags_o   <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        rel_o     <= rel_d;
        status_o  <= sts_d;
        flags_o   <= fl_d;
        invalid_o <= inv_d;
      end
    end
  end

  localparam logic [FLAG_W-1:0] FL_KEEP =
    ~FLAG_W'((1 << FL_CF) | (1 << FL_PF) | (1 << FL_ZF));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(status_o) && $stable(flags_o) && $stable(rel_o)));

  assert_sts_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((status_o & ~STS_MASK) == ($past(status_i) & ~STS_MASK)));

  assert_fl_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((flags_o & FL_KEEP) == ($past(flags_i) & FL_KEEP)));

  // status and flags encodings agree bit for bit
  assert_cc_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flags_o[FL_ZF] == status_o[STS_C3] &&
                 flags_o[FL_PF] == status_o[STS_C2] &&
                 flags_o[FL_CF] == status_o[STS_C0]));

  assert_ordered_cc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && rel_o != REL_UN) |->
      ($countones(status_o & STS_MASK) <= 1 && !status_o[STS_C2]));

  assert_inv_unord_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && invalid_o) |-> rel_o == REL_UN);

  assert_quiet_qnan_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && quiet_i && !sel_info[0].snan && !sel_info[1].snan) |=> !invalid_o);
endmodule

// File: tb/test_fcmp_flags.sv
`timescale 1ns/1ps
module test_fcmp_flags;
  localparam int FLAG_W = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0, fmt64_i = 1'b0, quiet_i = 1'b0;
  logic [63:0]       a_i = '0, b_i = '0;
  logic [15:0]       status_i = '0;
  logic [FLAG_W-1:0] flags_i = '0;
  logic              valid_o, invalid_o;
  logic [1:0]        rel_o;
  logic [15:0]       status_o;
  logic [FLAG_W-1:0] flags_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fcmp_flags #(.FLAG_W(FLAG_W)) i_fcmp_flags (
    .clk_i(clk), .rst_ni, .valid_i, .fmt64_i, .quiet_i, .a_i, .b_i,
    .status_i, .flags_i, .valid_o, .rel_o, .status_o, .flags_o, .invalid_o
  );

  localparam logic [1:0] GT = 2'd0, LT = 2'd1, EQ = 2'd2, UN = 2'd3;

  localparam logic [31:0] S_P1 = 32'h3F80_0000, S_P2 = 32'h4000_0000,
                          S_N1 = 32'hBF80_0000, S_N2 = 32'hC000_0000,
                          S_PZ = 32'h0000_0000, S_NZ = 32'h8000_0000,
                          S_INF = 32'h7F80_0000, S_QN = 32'h7FC0_0000,
                          S_SN = 32'h7F80_0001;
  localparam logic [63:0] D_P1 = 64'h3FF0_0000_0000_0000,
                          D_P2 = 64'h4000_0000_0000_0000,
                          D_N2 = 64'hC000_0000_0000_0000,
                          D_QN = 64'h7FF8_0000_0000_0000,
                          D_SN = 64'h7FF0_0000_0000_0001;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_sts(logic [1:0] r, logic [15:0] s);
    logic [15:0] cc;
    case (r)
      LT: cc = 16'h0100;
      EQ: cc = 16'h4000;
      UN: cc = 16'h4500;
      default: cc = 16'h0000;
    endcase
    return (s & ~16'h4500) | cc;
  endfunction

  function automatic logic [FLAG_W-1:0] exp_fl(logic [1:0] r, logic [FLAG_W-1:0] f);
    logic [FLAG_W-1:0] v;
    v = '0;
    case (r)
      LT: v[0] = 1'b1;
      EQ: v[6] = 1'b1;
      UN: begin v[0] = 1'b1; v[2] = 1'b1; v[6] = 1'b1; end
      default: ;
    endcase
    return (f & ~FLAG_W'(32'h45)) | v;
  endfunction

  // drive at negedge, result registered at the next posedge, sample at the following negedge
  task automatic cmp(string req, logic f64, logic q, logic [63:0] a, logic [63:0] b,
                     logic [15:0] s, logic [FLAG_W-1:0] f, logic [1:0] er, logic ei);
    @(negedge clk);
    valid_i = 1'b1; fmt64_i = f64; quiet_i = q; a_i = a; b_i = b;
    status_i = s; flags_i = f;
    @(negedge clk);
    valid_i = 1'b0;
    chk({req, " valid"}, 64'(valid_o), 64'd1);
    chk({req, " rel"}, 64'(rel_o), 64'(er));
    chk({req, " status"}, 64'(status_o), 64'(exp_sts(er, s)));
    chk({req, " flags"}, 64'(flags_o), 64'(exp_fl(er, f)));
    chk({req, " invalid"}, 64'(invalid_o), 64'(ei));
  endtask

  task automatic t_reset;
    chk("R1 valid", 64'(valid_o), 0);
    chk("R1 rel", 64'(rel_o), 0);
    chk("R1 status", 64'(status_o), 0);
    chk("R1 flags", 64'(flags_o), 0);
    chk("R1 invalid", 64'(invalid_o), 0);
  endtask

  task automatic t_basic;
    cmp("R3 R5 lt", 0, 0, {32'h0, S_P1}, {32'h0, S_P2}, 16'h0, '0, LT, 0);
    cmp("R3 R5 gt", 0, 0, {32'h0, S_P2}, {32'h0, S_P1}, 16'h0, '0, GT, 0);
    cmp("R3 R5 eq", 0, 0, {32'h0, S_P2}, {32'h0, S_P2}, 16'h0, '0, EQ, 0);
  endtask

  task automatic t_passthru;
    cmp("R4 R6 busy lt", 0, 0, {32'h0, S_N1}, {32'h0, S_P1}, 16'hFFFF, '1, LT, 0);
    cmp("R4 R6 busy gt", 0, 0, {32'h0, S_P1}, {32'h0, S_N1}, 16'hBAFE, 32'hDEAD_BEEF, GT, 0);
    cmp("R4 R6 busy un", 0, 1, {32'h0, S_QN}, {32'h0, S_P1}, 16'h1234, 32'h1234_5678, UN, 0);
  endtask

  task automatic t_order;
    cmp("R8 zeros", 0, 0, {32'h0, S_PZ}, {32'h0, S_NZ}, 16'h0, '0, EQ, 0);
    cmp("R8 neg lt", 0, 0, {32'h0, S_N2}, {32'h0, S_N1}, 16'h0, '0, LT, 0);
    cmp("R8 neg gt", 0, 0, {32'h0, S_N1}, {32'h0, S_N2}, 16'h0, '0, GT, 0);
    cmp("R8 nz vs p", 0, 0, {32'h0, S_NZ}, {32'h0, S_P1}, 16'h0, '0, LT, 0);
    cmp("R8 inf", 0, 0, {32'h0, S_INF}, {32'h0, S_P2}, 16'h0, '0, GT, 0);
    cmp("R8 dp neg", 1, 0, D_N2, D_P1, 16'h0, '0, LT, 0);
  endtask

  task automatic t_format;
    cmp("R9 sp hi ignored", 0, 0, {32'hFFFF_FFFF, S_P1}, {32'h0, S_P2}, 16'h0, '0, LT, 0);
    cmp("R9 sp hi nan ignored", 0, 0, {32'h7FF8_0000, S_P1}, {32'h7FF8_0000, S_P1},
        16'h0, '0, EQ, 0);
    cmp("R9 dp", 1, 0, D_P2, D_P1, 16'h0, '0, GT, 0);
  endtask

  task automatic t_nan;
    cmp("R7 R10 sig qnan a", 0, 0, {32'h0, S_QN}, {32'h0, S_P1}, 16'h0, '0, UN, 1);
    cmp("R7 R10 sig snan b", 0, 0, {32'h0, S_P1}, {32'h0, S_SN}, 16'h0, '0, UN, 1);
    cmp("R7 R11 quiet qnan", 0, 1, {32'h0, S_P1}, {32'h0, S_QN}, 16'h0, '0, UN, 0);
    cmp("R7 R11 quiet snan", 0, 1, {32'h0, S_SN}, {32'h0, S_P1}, 16'h0, '0, UN, 1);
    cmp("R7 R11 dp quiet qnan", 1, 1, D_QN, D_P1, 16'h0, '0, UN, 0);
    cmp("R7 R11 dp quiet snan", 1, 1, D_P1, D_SN, 16'h0, '0, UN, 1);
    cmp("R7 R10 dp sig qnan", 1, 0, D_P1, D_QN, 16'h0, '0, UN, 1);
    cmp("R10 ordered no inv", 0, 0, {32'h0, S_INF}, {32'h0, S_INF}, 16'h0, '0, EQ, 0);
  endtask

  task automatic t_hold;
    logic [15:0] s0;
    logic [FLAG_W-1:0] f0;
    cmp("R2 setup", 0, 0, {32'h0, S_P1}, {32'h0, S_P2}, 16'h00F0, 32'hF0, LT, 0);
    s0 = status_o; f0 = flags_o;
    @(negedge clk);
    a_i = {32'h0, S_QN}; status_i = 16'hFFFF; flags_i = '1;
    @(negedge clk);
    chk("R2 valid low", 64'(valid_o), 0);
    chk("R2 status hold", 64'(status_o), 64'(s0));
    chk("R2 flags hold", 64'(flags_o), 64'(f0));
    chk("R2 rel hold", 64'(rel_o), 64'(LT));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_basic();
    t_passthru();
    t_order();
    t_format();
    t_nan();
    t_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule